// File: doc/BRIEF.md
# Simultaneous-Sample ADC Scan Sequencer

This block runs the digital side of an eight-channel converter whose inputs are all sampled at one instant. Software writes a channel-enable mask over a 16-bit register bus. A read of the start address then launches one conversion cycle. A behavioural converter model, timed in clock cycles, produces a 14-bit two's-complement word for each enabled channel. At the end of the cycle these words are loaded into a result FIFO, lowest-numbered channel first, and an active-low end-of-conversion flag drops.

The FIFO is drained through eight aliased word addresses. A host that splits a 32-bit access into two back-to-back 16-bit reads therefore receives two successive results. Every start empties the FIFO. A start issued during a running conversion abandons that conversion and begins a new one.

Top module: `adc_scan_seq`

## Requirements
- R1: A bus write to byte address 0x00 stores busWdata[7:0] as the channel-enable mask, where bit k enables channel k. Bits 15:8 of the written word are ignored.
- R2: A bus read of byte address 0x20 (or 0x21) starts a conversion. Every enabled channel's anaIn word is captured on that same clock edge, and later changes of anaIn do not alter the results.
- R3: eocN is 1 after reset. After a start with n > 0 enabled channels, eocN is 1 from the next cycle onward. It falls exactly BASE_CYC + PER_CH_CYC*n cycles after the start edge and then stays 0 until the next start.
- R4: A start empties the result FIFO, so results left from an earlier conversion are never returned after it.
- R5: When a conversion completes, the FIFO holds exactly the enabled channels' captured words, in ascending channel number.
- R6: Reads at byte addresses 0x00 through 0x0F all pop the same FIFO, so reads at 0x00, 0x02, …, 0x0E return successive results.
- R7: Read data is registered: busRdata carries the value one cycle after the read. A result appears in bits 13:0 and bits 15:14 are 0.
- R8: A read of an empty FIFO returns 0 and leaves the FIFO state intact, so the next conversion's results still come out in order.
- R9: A start with an all-zero mask drives eocN to 0 on the next cycle and leaves the FIFO empty.
- R10: A start during a running conversion restarts the timer, using the mask and the anaIn values present at the new start.
- R11: A read of any address other than 0x00–0x0F returns 0 and does not pop the FIFO. This includes the start address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (6) | Byte address of the access |
| busRead | input | 1 | Read strobe, one cycle per access |
| busWrite | input | 1 | Write strobe, one cycle per access |
| busWdata | input | BUS_W (16) | Write data |
| busRdata | output | BUS_W (16) | Registered read data |
| anaIn | input | NUM_CH*DATA_W (112) | Converter model input: channel k in bits k*14 +: 14 |
| eocN | output | 1 | End of conversion, low when results are ready |

## Verification
The bench targets five corner cases:
- Reads past the last result. A design that let its read pointer wrap or underflow would return stale words, or would scramble the order of the next conversion.
- A restart part-way through a conversion. A design that kept the old timer or the old mask would drop eocN at the wrong cycle or return the abandoned channels.
- A start with an empty mask. A design that treated it as a normal conversion would hold eocN high for BASE_CYC cycles instead of dropping it at once.
- Writes whose upper byte is set. A design that did not ignore those bits would pick up extra channels.
- Reads of the start address and other non-data addresses. A design that decoded these as data reads would silently consume results.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic capture;  // latch all channel inputs and the mask
    logic flush;    // empty the result FIFO
    logic load;     // conversion finished: fill FIFO with packed results
  } scanStrobe_t;

endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int BASE_CYC   = 130,
  parameter int PER_CH_CYC = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startRd,
  input  logic [NUM_CH-1:0] chanMask,
  output scanStrobe_t       strb,
  output logic              eocN
);

  localparam int MAX_LAT = BASE_CYC + PER_CH_CYC * NUM_CH;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);
  localparam int NCH_W   = $clog2(NUM_CH + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [NCH_W-1:0] nCh;
  logic [CNT_W-1:0] lat;

  always_comb begin
    nCh = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      nCh = nCh + NCH_W'(chanMask[k]);
    end
    lat = CNT_W'(BASE_CYC + PER_CH_CYC * int'(nCh));
  end

  always_comb begin
    strb.capture = startRd;
    strb.flush   = startRd;
    strb.load    = busy && (cnt == '0) && !startRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
      eocN <= 1'b1;
    end else if (startRd) begin
      if (nCh == '0) begin
        busy <= 1'b0;
        cnt  <= '0;
        eocN <= 1'b0;
      end else begin
        busy <= 1'b1;
        cnt  <= lat - CNT_W'(1);
        eocN <= 1'b1;
      end
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        eocN <= 1'b0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R3
  start_eoc_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startRd && (chanMask != '0)) |=> eocN);

  // R9
  zero_mask_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startRd && (chanMask == '0)) |=> (!eocN && !busy));

  // R3
  eoc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!eocN && !startRd) |=> !eocN);

endmodule

// File: rtl/adc_scan_dpath.sv
module adc_scan_dpath
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 14,
  parameter int BUS_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ctrlWr,
  input  logic [BUS_W-1:0]         wdata,
  input  logic                     dataRd,
  input  logic                     otherRd,
  input  logic [NUM_CH*DATA_W-1:0] anaIn,
  input  scanStrobe_t              strb,
  output logic [NUM_CH-1:0]        chanMask,
  output logic [BUS_W-1:0]         rdata
);

  localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CNT_W = $clog2(NUM_CH + 1);

  logic [NUM_CH-1:0] sampMask;
  logic [DATA_W-1:0] sampVal  [NUM_CH];
  logic [DATA_W-1:0] packedVal[NUM_CH];
  logic [DATA_W-1:0] fifoMem  [NUM_CH];
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  fifoCount;
  logic [CNT_W-1:0]  slot;
  logic              fifoEmpty;
  logic              pop;

  // Channel-enable mask register: upper bus bits ignored
  always_ff @(posedge clk) begin
    if (!rstN)       chanMask <= '0;
    else if (ctrlWr) chanMask <= wdata[NUM_CH-1:0];
  end

  // Simultaneous sample-and-hold, one register per channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rstN)             sampVal[ch] <= '0;
      else if (strb.capture) sampVal[ch] <= anaIn[ch*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             sampMask <= '0;
    else if (strb.capture) sampMask <= chanMask;
  end

  // Pack enabled channels to the front, ascending channel order
  always_comb begin
    slot = '0;
    for (int k = 0; k < NUM_CH; k++) packedVal[k] = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (sampMask[ch]) begin
        packedVal[slot[PTR_W-1:0]] = sampVal[ch];
        slot = slot + CNT_W'(1);
      end
    end
  end

  assign fifoEmpty = (fifoCount == '0);
  assign pop       = dataRd && !fifoEmpty;

  always_ff @(posedge clk) begin
    if (strb.load) begin
      for (int k = 0; k < NUM_CH; k++) fifoMem[k] <= packedVal[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr     <= '0;
      fifoCount <= '0;
    end else if (strb.flush) begin
      rdPtr     <= '0;
      fifoCount <= '0;
    end else if (strb.load) begin
      rdPtr     <= '0;
      fifoCount <= slot;
    end else if (pop) begin
      rdPtr     <= rdPtr + PTR_W'(1);
      fifoCount <= fifoCount - CNT_W'(1);
    end
  end

  // Registered read port, reserved bits zero
  always_ff @(posedge clk) begin
    if (!rstN)             rdata <= '0;
    else if (pop)          rdata <= {{(BUS_W-DATA_W){1'b0}}, fifoMem[rdPtr]};
    else if (dataRd || otherRd) rdata <= '0;
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(NUM_CH));

  // R5
  load_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (fifoCount == CNT_W'($countones($past(sampMask)))));

  // R4
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (fifoCount == '0));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && fifoEmpty && !strb.load && !strb.flush) |=> ($stable(rdPtr) && fifoEmpty));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int            NUM_CH     = 8,
  parameter int            DATA_W     = 14,
  parameter int            BUS_W      = 16,
  parameter int            ADDR_W     = 6,
  parameter int            BASE_CYC   = 130,
  parameter int            PER_CH_CYC = 30,
  parameter logic [5:0]    CTRL_ADDR  = 6'h00,
  parameter logic [5:0]    DATA_ADDR  = 6'h00,
  parameter logic [5:0]    START_ADDR = 6'h20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busRead,
  input  logic                     busWrite,
  input  logic [BUS_W-1:0]         busWdata,
  output logic [BUS_W-1:0]         busRdata,
  input  logic [NUM_CH*DATA_W-1:0] anaIn,
  output logic                     eocN
);

  // Mirror window spans NUM_CH 16-bit words
  localparam int MIRROR_BITS = $clog2(NUM_CH) + 1;

  logic              ctrlWr;
  logic              startRd;
  logic              dataRd;
  logic              otherRd;
  logic [NUM_CH-1:0] chanMask;
  scanStrobe_t       strb;

  assign ctrlWr  = busWrite && ((busAddr >> 1) == (ADDR_W'(CTRL_ADDR) >> 1));
  assign startRd = busRead && ((busAddr >> 1) == (ADDR_W'(START_ADDR) >> 1));
  assign dataRd  = busRead && ((busAddr >> MIRROR_BITS) == (ADDR_W'(DATA_ADDR) >> MIRROR_BITS));
  assign otherRd = busRead && !dataRd;

  adc_scan_ctrl #(
    .NUM_CH(NUM_CH), .BASE_CYC(BASE_CYC), .PER_CH_CYC(PER_CH_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startRd(startRd), .chanMask(chanMask),
    .strb(strb), .eocN(eocN)
  );

  adc_scan_dpath #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .BUS_W(BUS_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .wdata(busWdata),
    .dataRd(dataRd), .otherRd(otherRd), .anaIn(anaIn), .strb(strb),
    .chanMask(chanMask), .rdata(busRdata)
  );

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[BUS_W-1:DATA_W] == '0);

  // R11
  other_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    otherRd |=> (busRdata == '0));

endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb_top;

  localparam int NUM_CH = 8;
  localparam int DW     = 14;
  localparam int BASE   = 130;
  localparam int PER    = 30;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [5:0]        busAddr = '0;
  logic              busRead = 1'b0;
  logic              busWrite = 1'b0;
  logic [15:0]       busWdata = '0;
  logic [15:0]       busRdata;
  logic [NUM_CH*DW-1:0] anaIn = '0;
  logic              eocN;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string curReq = "R5";
  logic [7:0] modelMask = '0;
  logic [15:0] expQ[$];
  logic [1:0] monKind = 2'd0;

  always #5 clk = ~clk;

  adc_scan_seq dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata),
    .anaIn(anaIn), .eocN(eocN)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: arm on the edge that takes the read, compare at the next negedge
  always @(posedge clk) begin
    if (busRead) monKind <= (busAddr < 6'h10) ? 2'd1 : 2'd2;
    else         monKind <= 2'd0;
  end

  always @(negedge clk) begin
    if (monKind == 2'd1) begin
      if (expQ.size() > 0) chk(curReq, busRdata, expQ.pop_front());
      else                 chk("R8", busRdata, 16'h0000);
    end else if (monKind == 2'd2) begin
      chk("R11", busRdata, 16'h0000);
    end
  end

  task automatic busWr(input logic [5:0] a, input logic [15:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [5:0] a);
    busAddr = a; busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0;
  endtask

  task automatic setSample(input int ch, input logic [DW-1:0] v);
    anaIn[ch*DW +: DW] = v;
  endtask

  task automatic writeMask(input logic [15:0] w);
    busWr(6'h00, w);
    modelMask = w[7:0];
  endtask

  // Driver: start and push scoreboard expectations
  task automatic startConv();
    expQ.delete();
    for (int ch = 0; ch < NUM_CH; ch++)
      if (modelMask[ch]) expQ.push_back({2'b00, anaIn[ch*DW +: DW]});
    busRd(6'h20);
  endtask

  function automatic int countBits(input logic [7:0] m);
    int c = 0;
    for (int k = 0; k < 8; k++) c += int'(m[k]);
    return c;
  endfunction

  // Called at the negedge right after the start edge
  task automatic checkTiming(input int n);
    int lat = BASE + PER * n;
    chk("R3", {15'd0, eocN}, 16'd1);
    repeat (lat - 1) @(negedge clk);
    chk("R3", {15'd0, eocN}, 16'd1);
    @(negedge clk);
    chk("R3", {15'd0, eocN}, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R3 watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R3", {15'd0, eocN}, 16'd1);
    chk("R7", busRdata, 16'h0000);
    busRd(6'h00);                              // R8 empty read
    @(negedge clk);

    // Full mask, all mirrors, negative codes
    curReq = "R6";
    for (int ch = 0; ch < NUM_CH; ch++) setSample(ch, DW'(14'h0101 * ch + 14'h2000));
    setSample(7, 14'h3FFF);
    writeMask(16'h00FF);
    startConv();
    for (int ch = 0; ch < NUM_CH; ch++) setSample(ch, 14'h1555);  // R2 later change ignored
    checkTiming(8);
    for (int k = 0; k < 8; k++) busRd(6'(2 * k));
    @(negedge clk);
    chk("R5", 16'(expQ.size()), 16'd0);

    // R1: upper byte ignored, sparse mask, R8 empty reads then reload
    curReq = "R1";
    for (int ch = 0; ch < NUM_CH; ch++) setSample(ch, DW'(14'h0011 * (ch + 1)));
    busWr(6'h00, 16'hAB5A);
    modelMask = 8'h5A;
    startConv();
    checkTiming(countBits(8'h5A));
    for (int k = 0; k < 4; k++) busRd(6'h00);
    busRd(6'h04);
    busRd(6'h06);
    @(negedge clk);
    curReq = "R8";
    setSample(2, 14'h0ABC);
    setSample(5, 14'h1234);
    writeMask(16'h0024);
    startConv();
    checkTiming(2);
    busRd(6'h08);
    busRd(6'h0A);
    @(negedge clk);

    // R4: leftovers flushed by a new start
    curReq = "R4";
    setSample(0, 14'h0AAA); setSample(1, 14'h0BBB); setSample(7, 14'h2222);
    writeMask(16'h0083);
    startConv();
    checkTiming(3);
    busRd(6'h00);
    writeMask(16'h0080);
    setSample(7, 14'h3333);
    startConv();
    checkTiming(1);
    busRd(6'h00);
    busRd(6'h02);                              // empty after one: 0
    @(negedge clk);

    // R9: zero mask completes at once, FIFO empty
    curReq = "R9";
    writeMask(16'h0003);
    startConv();
    checkTiming(2);
    writeMask(16'h0000);
    startConv();
    chk("R9", {15'd0, eocN}, 16'd0);
    busRd(6'h00);
    @(negedge clk);

    // R10: restart mid-conversion with a new mask and new inputs
    curReq = "R10";
    for (int ch = 0; ch < NUM_CH; ch++) setSample(ch, 14'h0F0F);
    writeMask(16'h000F);
    startConv();
    repeat (50) @(negedge clk);
    setSample(3, 14'h2468);
    writeMask(16'h0008);
    startConv();
    checkTiming(1);
    busRd(6'h0E);
    busRd(6'h00);
    @(negedge clk);

    // R11: non-data reads do not pop; R3 flag holds low
    curReq = "R11";
    setSample(4, 14'h0444); setSample(6, 14'h0666);
    writeMask(16'h0050);
    startConv();
    checkTiming(2);
    busRd(6'h10);
    busRd(6'h22);
    busRd(6'h00);
    busRd(6'h02);
    repeat (100) @(negedge clk);
    chk("R3", {15'd0, eocN}, 16'd0);
    chk("R11", 16'(expQ.size()), 16'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule